// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides which interrupt the core takes, and when. It watches six request sources. The external source is a falling edge on an active-low line. The other five are single-cycle event pulses from timer 0, timer 1, a peripheral group, a one-second real-time clock and a multi-function group. Each source has its own latched flag. The block also keeps one enable bit per source and one global enable.

Requests are judged only on clock edges where the core's polling strobe is high. Anything that arrived since the previous strobe is handled there. On such an edge the block picks the highest-priority source that is flagged and enabled. It does so only if the global enable is set and the core's return-address stack has room. It then raises a one-cycle call request with the matching vector address. In the same edge it clears that source's flag and the global enable. A return strobe from the core sets the global enable again. Software can overwrite the flag and enable registers as whole words, and both registers can be read back on output ports.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high, `call_req` is 0, `call_vec` is 00H, all six flags are 0, and all seven enable bits are 0.
- R2: Flag bit 0 (external) is set by the first clock edge at which `ext_line_n` is 0 after having been 1 at the previous edge. A line that stays low, or that rises, sets nothing.
- R3: Flag bits 1 to 5 belong to timer 0, timer 1, peripheral, real-time clock and multi-function, in that order. Each is set by the edge at which `evt_pulse[k]` is 1, with bit k of `evt_pulse` feeding flag bit k+1.
- R4: A source is taken only when all four conditions hold: its flag is set, its enable bit is set, the global enable (`en_q[6]`) is set, and `stack_full` is 0. A flag that is masked stays latched and is taken once the conditions hold.
- R5: Sources are examined only at edges where `poll_stb` is 1. `call_req` goes to 1 in the cycle after that edge and lasts exactly one cycle.
- R6: When several eligible sources are flagged, the lowest flag index wins. Only one source is taken per polling edge, and the others keep their flags.
- R7: `call_vec` equals 04H + 4 × (source index). That gives 04H, 08H, 0CH, 10H, 14H and 18H. The value holds until the next call.
- R8: At the edge that takes a source, that source's flag and the global enable are both cleared.
- R9: `ret_stb` sets the global enable. When it coincides with a take, the take wins and the global enable ends up 0.
- R10: `sw_flag_we` loads all six flags from `sw_flag_data`, and a 1 written there raises a request. `sw_en_we` loads `sw_en_data`: bits 0 to 5 are the per-source enables and bit 6 is the global enable.
- R11: A hardware set that arrives at the same edge that clears the same flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_stb | input | 1 | Core phase strobe; requests are judged on edges where it is high |
| ext_line_n | input | 1 | External interrupt line, active low, synchronous to clk |
| evt_pulse | input | 5 | Event pulses: timer 0, timer 1, peripheral, RTC, multi-function |
| stack_full | input | 1 | Core return stack has no free entry |
| ret_stb | input | 1 | Core returned from an interrupt routine |
| sw_flag_we | input | 1 | Software write strobe for the flag register |
| sw_flag_data | input | 6 | Software flag value |
| sw_en_we | input | 1 | Software write strobe for the enable register |
| sw_en_data | input | 7 | Software enable value, bit 6 global |
| call_req | output | 1 | One-cycle vectored call request to the core |
| call_vec | output | 8 | Vector address of the last call |
| flag_q | output | 6 | Current request flags |
| en_q | output | 7 | Current enables, bit 6 global |

## Verification
Flags and enables are updated at the same edge that samples their cause, so they can be read one edge after a pulse, a falling line or a software write. `call_req`, `call_vec` and the clearing of the taken flag and the global enable all appear together, one edge after the polling edge. The bench drives every input on the falling clock edge and reads the results at the next falling edge, which lands half a period after the edge that produced them. Pulse length is checked one further edge later.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    // Number of request sources and width of the vector output.
    localparam int SRC_COUNT = 6;
    localparam int VEC_W     = 8;

    // Source indices; lower index means higher priority.
    typedef enum logic [2:0] {
        SRC_EXT  = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_TMR1 = 3'd2,
        SRC_PERI = 3'd3,
        SRC_RTC  = 3'd4,
        SRC_MF   = 3'd5
    } src_e;

    // Vector address for a source index.
    function automatic logic [VEC_W-1:0] vec_of(input int base, input int step, input int idx);
        return VEC_W'(base + step * idx);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = irq_ctrl_pkg::SRC_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_line_n,
    input  logic [NSRC-2:0] evt_pulse,
    input  logic            sw_we,
    input  logic [NSRC-1:0] sw_data,
    input  logic [NSRC-1:0] svc_clr,
    output logic [NSRC-1:0] flag_q
);
    logic            ext_prev;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] base_val;

    // Falling edge on the external line plus the event pulses.
    assign hw_set   = {evt_pulse, ext_prev & ~ext_line_n};
    assign base_val = sw_we ? sw_data : flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= 1'b1;
            flag_q   <= '0;
        end else begin
            ext_prev <= ext_line_n;
            // Service clear first, then new hardware sets win (R11).
            flag_q   <= (base_val & ~svc_clr) | hw_set;
        end
    end

    // R3 / R11: a hardware set always lands in the flag.
    a_r11_set_lands: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));

    // R8: a service clear without a coincident set empties the flag.
    a_r8_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (|(svc_clr & ~hw_set)) |=> ((flag_q & $past(svc_clr & ~hw_set)) == '0));

endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
    parameter int NSRC = irq_ctrl_pkg::SRC_COUNT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we,
    input  logic [NSRC:0]   sw_data,
    input  logic            ret_stb,
    input  logic            take,
    output logic            gie_q,
    output logic [NSRC-1:0] src_en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q    <= 1'b0;
            src_en_q <= '0;
        end else begin
            if (sw_we) begin
                gie_q    <= sw_data[NSRC];
                src_en_q <= sw_data[NSRC-1:0];
            end
            if (ret_stb) gie_q <= 1'b1;
            if (take)    gie_q <= 1'b0;
        end
    end

    // R9: a take always leaves the global enable cleared.
    a_r9_take_clears_gie: assert property (@(posedge clk) disable iff (rst)
        take |=> !gie_q);

    // R9: a return without a take re-enables.
    a_r9_return_sets_gie: assert property (@(posedge clk) disable iff (rst)
        (ret_stb && !take) |=> gie_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC = irq_ctrl_pkg::SRC_COUNT,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] elig,
    output logic            any,
    output logic [NSRC-1:0] grant,
    output logic [IW-1:0]   idx
);
    // Walk from lowest priority upward so the lowest index wins.
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end

    // R6: at most one winner, and only an eligible one.
    a_r6_one_winner: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~elig) == '0));

    // R6: no eligible source above the winner.
    a_r6_highest_wins: assert property (@(posedge clk) disable iff (rst)
        any |-> ((elig & (grant - 1'b1)) == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NSRC     = SRC_COUNT,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4,
    localparam int IW      = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_stb,
    input  logic              ext_line_n,
    input  logic [NSRC-2:0]   evt_pulse,
    input  logic              stack_full,
    input  logic              ret_stb,
    input  logic              sw_flag_we,
    input  logic [NSRC-1:0]   sw_flag_data,
    input  logic              sw_en_we,
    input  logic [NSRC:0]     sw_en_data,
    output logic              call_req,
    output logic [VEC_W-1:0]  call_vec,
    output logic [NSRC-1:0]   flag_q,
    output logic [NSRC:0]     en_q
);
    logic            gie_q;
    logic [NSRC-1:0] src_en_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] svc_clr;
    logic [IW-1:0]   win_idx;
    logic            any_elig;
    logic            take;

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .ext_line_n (ext_line_n),
        .evt_pulse  (evt_pulse),
        .sw_we      (sw_flag_we),
        .sw_data    (sw_flag_data),
        .svc_clr    (svc_clr),
        .flag_q     (flag_q)
    );

    irq_enable_regs #(.NSRC(NSRC)) u_enables (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_en_we),
        .sw_data  (sw_en_data),
        .ret_stb  (ret_stb),
        .take     (take),
        .gie_q    (gie_q),
        .src_en_q (src_en_q)
    );

    assign elig = flag_q & src_en_q & {NSRC{gie_q}};

    irq_prio_pick #(.NSRC(NSRC)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .elig  (elig),
        .any   (any_elig),
        .grant (grant),
        .idx   (win_idx)
    );

    assign take    = poll_stb && !stack_full && any_elig;
    assign svc_clr = take ? grant : '0;
    assign en_q    = {gie_q, src_en_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            call_req <= 1'b0;
            call_vec <= '0;
        end else begin
            call_req <= take;
            if (take) call_vec <= vec_of(VEC_BASE, VEC_STEP, int'(win_idx));
        end
    end

    // R5 / R4: a call follows only a polling edge with room on the stack.
    a_r5_only_on_poll: assert property (@(posedge clk) disable iff (rst)
        call_req |-> $past(poll_stb && !stack_full && gie_q));

    // R5: the call request is a single-cycle pulse.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        call_req |=> !call_req);

    // R7: the vector lies on the table grid.
    a_r7_vec_on_grid: assert property (@(posedge clk) disable iff (rst)
        call_req |-> (call_vec >= VEC_W'(VEC_BASE) && call_vec[1:0] == 2'b00 &&
                      call_vec <= VEC_W'(VEC_BASE + VEC_STEP * (NSRC - 1))));

    // R8: the global enable is off while the call is presented.
    a_r8_gie_off_on_call: assert property (@(posedge clk) disable iff (rst)
        call_req |-> !en_q[NSRC]);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       poll_stb;
    logic       ext_line_n;
    logic [4:0] evt_pulse;
    logic       stack_full;
    logic       ret_stb;
    logic       sw_flag_we;
    logic [5:0] sw_flag_data;
    logic       sw_en_we;
    logic [6:0] sw_en_data;
    logic       call_req;
    logic [7:0] call_vec;
    logic [5:0] flag_q;
    logic [6:0] en_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .poll_stb(poll_stb), .ext_line_n(ext_line_n),
        .evt_pulse(evt_pulse), .stack_full(stack_full), .ret_stb(ret_stb),
        .sw_flag_we(sw_flag_we), .sw_flag_data(sw_flag_data),
        .sw_en_we(sw_en_we), .sw_en_data(sw_en_data),
        .call_req(call_req), .call_vec(call_vec), .flag_q(flag_q), .en_q(en_q)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic poll();
        poll_stb = 1'b1;
        tick();
        poll_stb = 1'b0;
    endtask

    task automatic wr_flags(input logic [5:0] v);
        sw_flag_we = 1'b1; sw_flag_data = v;
        tick();
        sw_flag_we = 1'b0;
    endtask

    task automatic wr_en(input logic [6:0] v);
        sw_en_we = 1'b1; sw_en_data = v;
        tick();
        sw_en_we = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; poll_stb = 0; ext_line_n = 1; evt_pulse = '0; stack_full = 0;
        ret_stb = 0; sw_flag_we = 0; sw_flag_data = '0; sw_en_we = 0; sw_en_data = '0;
        repeat (3) tick();
        chk(call_req, 0, "R1 call_req");
        chk(call_vec, 8'h00, "R1 call_vec");
        chk(flag_q, 0, "R1 flags");
        chk(en_q, 0, "R1 enables");
        rst = 1'b0;
        tick();
    endtask

    task automatic t_ext_edge();
        ext_line_n = 0; tick();
        chk(flag_q, 6'h01, "R2 falling edge sets ext flag");
        wr_flags('0);
        tick();
        chk(flag_q, 6'h00, "R2 held low sets nothing");
        ext_line_n = 1; tick();
        chk(flag_q, 6'h00, "R2 rising edge sets nothing");
        ext_line_n = 0; tick();
        chk(flag_q, 6'h01, "R2 second falling edge");
        ext_line_n = 1;
        wr_flags('0);
    endtask

    task automatic t_events();
        for (int k = 0; k < 5; k++) begin
            evt_pulse = 5'(1 << k); tick(); evt_pulse = '0;
            chk(flag_q, 32'(1 << (k + 1)), "R3 event pulse to flag");
            wr_flags('0);
        end
    endtask

    task automatic t_mask();
        wr_flags(6'b000100);
        poll();
        chk(call_req, 0, "R4 no enables, no call");
        chk(flag_q, 6'b000100, "R4 masked flag stays");
        wr_en(7'b0000100);
        poll();
        chk(call_req, 0, "R4 global off, no call");
        wr_en(7'b1000100);
        chk(en_q, 7'b1000100, "R10 enable readback");
        stack_full = 1;
        poll();
        chk(call_req, 0, "R4 stack full, no call");
        chk(flag_q, 6'b000100, "R4 flag kept while stack full");
        stack_full = 0;
        repeat (3) tick();
        chk(call_req, 0, "R5 no poll, no call");
        poll();
        chk(call_req, 1, "R4 call when all conditions hold");
        chk(call_vec, 8'h0C, "R7 timer1 vector");
        chk(flag_q, 0, "R8 flag cleared");
        chk(en_q[6], 0, "R8 global cleared");
        tick();
        chk(call_req, 0, "R5 one-cycle pulse");
        chk(call_vec, 8'h0C, "R7 vector holds");
    endtask

    task automatic t_priority();
        wr_flags(6'h3F);
        wr_en(7'h7F);
        for (int i = 0; i < 6; i++) begin
            poll();
            chk(call_req, 1, "R6 call taken");
            chk(call_vec, 32'(4 + 4 * i), "R7 R6 vector by priority");
            chk(flag_q, 32'(6'h3F & ~6'((1 << (i + 1)) - 1)), "R6 only winner cleared");
            poll();
            chk(call_req, 0, "R8 global off blocks next");
            ret_stb = 1; tick(); ret_stb = 0;
            chk(en_q[6], 1, "R9 return sets global");
        end
    endtask

    task automatic t_collide();
        wr_flags(6'b000010);
        poll_stb = 1; ret_stb = 1; evt_pulse = 5'b00001;
        tick();
        poll_stb = 0; ret_stb = 0; evt_pulse = '0;
        chk(call_req, 1, "R9 call with coincident return");
        chk(call_vec, 8'h08, "R7 timer0 vector");
        chk(en_q[6], 0, "R9 take beats return");
        chk(flag_q[1], 1, "R11 set beats clear");
        wr_flags('0);
        wr_en('0);
    endtask

    task automatic t_sw();
        wr_en(7'h55);
        chk(en_q, 7'h55, "R10 enable write");
        wr_flags(6'h2A);
        chk(flag_q, 6'h2A, "R10 flag write raises requests");
        wr_en(7'h48);
        poll();
        chk(call_req, 1, "R10 written flag serviced");
        chk(call_vec, 8'h10, "R7 peripheral vector");
        wr_flags('0);
    endtask

    initial begin
        t_reset();
        t_ext_edge();
        t_events();
        t_mask();
        t_priority();
        t_collide();
        t_sw();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule